// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error Flags

This block receives asynchronous serial frames on a single line. It samples the line on a clock enable that pulses sixteen times per bit period. It recovers frames of 5 to 8 data bits, an optional parity bit and a stop bit, and pushes each byte into a 16-entry receive queue. Each queued byte carries its own parity, framing and break flags. A line that has gone idle is held high. A frame begins with a low start bit, carries its data least significant bit first, and ends with a high stop bit.

The surrounding logic reads the queue from its head. It looks at `data_ready` and the head fields, then pulses `rd_pop` to move to the next entry. A frame that completes while the queue is full produces a one-cycle `ovr_evt` pulse. That frame is dropped and the queue is left as it was. Register decoding, interrupts and DMA handshakes belong to the surrounding logic.

Top module: `osr_rx`

## Requirements
- R1: After reset, and while the line stays high, `data_ready` and `ovr_evt` are 0 and no entry is queued.
- R2: A falling edge is taken as a start bit only if the line is still low at the 8th tick after it is detected. A low pulse shorter than that returns the receiver to idle and queues nothing.
- R3: Data bits are sampled every 16 ticks after the start bit is confirmed, and are assembled least significant bit first. `cfg_len` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the word length read as 0.
- R4: With `cfg_par_en`=1, a parity bit follows the data. The expected value depends on the other two parity inputs:
  - `cfg_par_stick`=0, `cfg_par_even`=1: the XOR of the data bits (even parity).
  - `cfg_par_stick`=0, `cfg_par_even`=0: the inverse of that XOR (odd parity).
  - `cfg_par_stick`=1, `cfg_par_even`=0: the parity bit must be 1.
  - `cfg_par_stick`=1, `cfg_par_even`=1: the parity bit must be 0.
  
  `rd_perr` is 1 on an entry whose parity bit did not match. It is 0 whenever parity is off.
- R5: A frame that completes while the queue holds 16 entries raises `ovr_evt` for one cycle. The frame's byte is discarded, and the existing entries and their order are kept.
- R6: `rd_ferr` is 1 on an entry whose first stop bit was sampled low. Only one stop bit is checked.
- R7: A frame in which every sample (data, parity and stop) is low is queued as a break. That entry has `rd_brk`=1, `rd_ferr`=1 and data 0. No further frame is accepted until the line returns high.
- R8: `data_ready` is 1 exactly while the queue is not empty. Entries leave the queue first in, first out. `rd_pop` with the queue non-empty removes the head entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Oversampling enable, 16 pulses per bit period |
| rx_in | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Word length: 0..3 selects 5..8 data bits |
| cfg_par_en | input | 1 | A parity bit follows the data |
| cfg_par_even | input | 1 | Even parity, or stick value 0 when stick mode is on |
| cfg_par_stick | input | 1 | Fixed parity value instead of a computed one |
| rd_pop | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| data_ready | output | 1 | Queue not empty |
| ovr_evt | output | 1 | One-cycle pulse: frame dropped because the queue was full |

## Verification
The bench covers the four parity modes in both directions, so a swapped sense of even and odd, or of the two stick values, shows up as a wrong `rd_perr`. Short words of 5 and 7 bits are checked for packing at the low end with zero fill; a design that shifted in from the top would deliver misplaced bits. A low glitch shorter than half a bit must leave the queue empty, and a design without start-bit confirmation would queue a spurious byte. A break held for more than a frame must give exactly one entry marked as a break, and a design without the wait for the line to go high would queue further bytes. Seventeen frames into a full queue must give one overrun pulse with the first sixteen bytes intact and in order; a design that overwrote entries or wrapped its pointers would fail that readback.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;

  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

endpackage

// File: rtl/osr_rx_sync.sv
module osr_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/osr_rx_frame.sv
module osr_rx_frame
  import osr_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_en,
  input  logic      rx,
  input  logic [1:0] cfg_len,
  input  logic      cfg_par_en,
  input  logic      cfg_par_even,
  input  logic      cfg_par_stick,
  output logic      frm_push,
  output rx_entry_t frm_entry
);

  localparam int unsigned CW = $clog2(OSR);
  localparam logic [CW-1:0] CNT_FULL = CW'(OSR - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(OSR / 2 - 1);

  rx_state_e         state_q, state_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [2:0]        bidx_q, bidx_n;
  logic [DATA_W-1:0] shr_q, shr_n;
  logic              par_q, par_n;
  logic              zero_q, zero_n;
  logic              push_q, push_n;
  rx_entry_t         ent_q, ent_n;

  logic [2:0] last_idx;
  logic       par_exp;

  assign last_idx = {1'b0, cfg_len} + 3'd4;
  assign par_exp  = cfg_par_stick ? ~cfg_par_even
                  : (cfg_par_even ? ^shr_q : ~^shr_q);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    bidx_n  = bidx_q;
    shr_n   = shr_q;
    par_n   = par_q;
    zero_n  = zero_q;
    push_n  = 1'b0;
    ent_n   = ent_q;
    if (tick_en) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!rx) begin
            cnt_n   = '0;
            state_n = ST_START;
          end
        end
        ST_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_n = '0;
            if (!rx) begin
              state_n = ST_DATA;
              bidx_n  = '0;
              shr_n   = '0;
              par_n   = 1'b0;
              zero_n  = 1'b1;
            end else begin
              state_n = ST_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == CNT_FULL) begin
            cnt_n = '0;
            shr_n[bidx_q] = rx;
            if (rx) zero_n = 1'b0;
            if (bidx_q == last_idx) state_n = cfg_par_en ? ST_PAR : ST_STOP;
            else                    bidx_n  = bidx_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt_q == CNT_FULL) begin
            cnt_n   = '0;
            par_n   = rx;
            if (rx) zero_n = 1'b0;
            state_n = ST_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == CNT_FULL) begin
            cnt_n      = '0;
            push_n     = 1'b1;
            ent_n.data = shr_q;
            ent_n.perr = cfg_par_en & (par_q != par_exp);
            ent_n.ferr = ~rx;
            ent_n.brk  = ~rx & zero_q;
            state_n    = rx ? ST_IDLE : ST_HOLD;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (rx) state_n = ST_IDLE;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      shr_q   <= '0;
      par_q   <= 1'b0;
      zero_q  <= 1'b0;
      push_q  <= 1'b0;
      ent_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bidx_q  <= bidx_n;
      shr_q   <= shr_n;
      par_q   <= par_n;
      zero_q  <= zero_n;
      push_q  <= push_n;
      ent_q   <= ent_n;
    end
  end

  assign frm_push  = push_q;
  assign frm_entry = ent_q;

endmodule

// File: rtl/osr_rx_fifo.sv
module osr_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       ovr
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] LVL_MAX = (AW+1)'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [AW:0]   lvl_q, lvl_n;
  logic          ovr_q, ovr_n;
  logic          do_wr, do_rd;

  assign empty = (lvl_q == '0);
  assign full  = (lvl_q == LVL_MAX);
  assign do_wr = push & ~full;
  assign do_rd = pop & ~empty;

  always_comb begin
    wp_n  = do_wr ? wp_q + 1'b1 : wp_q;
    rp_n  = do_rd ? rp_q + 1'b1 : rp_q;
    lvl_n = lvl_q;
    if (do_wr && !do_rd)      lvl_n = lvl_q + 1'b1;
    else if (!do_wr && do_rd) lvl_n = lvl_q - 1'b1;
    ovr_n = push & full;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      lvl_q <= lvl_n;
      ovr_q <= ovr_n;
    end
  end

  assign rdata = mem_q[rp_q];
  assign level = lvl_q;
  assign ovr   = ovr_q;

endmodule

// File: rtl/osr_rx.sv
module osr_rx
  import osr_rx_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned OSR       = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        rx_in,
  input  logic [1:0]  cfg_len,
  input  logic        cfg_par_en,
  input  logic        cfg_par_even,
  input  logic        cfg_par_stick,
  input  logic        rd_pop,
  output logic [7:0]  rd_data,
  output logic        rd_perr,
  output logic        rd_ferr,
  output logic        rd_brk,
  output logic        data_ready,
  output logic        ovr_evt
);

  localparam int unsigned EW = $bits(rx_entry_t);
  localparam int unsigned LW = $clog2(DEPTH) + 1;

  logic           rx_s;
  logic           frm_push;
  rx_entry_t      frm_entry;
  rx_entry_t      head;
  logic           fifo_empty;
  logic           fifo_full;
  logic [LW-1:0]  fifo_level;

  osr_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_in),
    .dout (rx_s)
  );

  osr_rx_frame #(.OSR(OSR)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_en      (tick_en),
    .rx           (rx_s),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_even (cfg_par_even),
    .cfg_par_stick(cfg_par_stick),
    .frm_push     (frm_push),
    .frm_entry    (frm_entry)
  );

  osr_rx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (frm_push),
    .wdata(frm_entry),
    .pop  (rd_pop),
    .rdata(head),
    .empty(fifo_empty),
    .full (fifo_full),
    .level(fifo_level),
    .ovr  (ovr_evt)
  );

  assign rd_data    = head.data;
  assign rd_perr    = head.perr;
  assign rd_ferr    = head.ferr;
  assign rd_brk     = head.brk;
  assign data_ready = ~fifo_empty;

endmodule

// File: rtl/osr_rx_chk.sv
module osr_rx_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rd_pop,
  input logic [7:0]              rd_data,
  input logic                    rd_ferr,
  input logic                    rd_brk,
  input logic                    data_ready,
  input logic                    ovr_evt,
  input logic                    frm_push,
  input logic                    fifo_full,
  input logic [$clog2(DEPTH):0]  fifo_level
);

  AST_OVR_KEEPS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_push && fifo_full && !rd_pop) |=> ($stable(fifo_level) && ovr_evt)); // R5

  AST_OVR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> $past(fifo_full) && $past(frm_push)); // R5

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(DEPTH)+1)'(DEPTH)); // R5

  AST_BRK_IS_ZERO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && rd_brk) |-> (rd_ferr && rd_data == 8'h00)); // R7

  AST_ONE_PUSH_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frm_push |=> !frm_push); // R3

  AST_READY_DROP_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(rd_pop)); // R8

endmodule

bind osr_rx osr_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_pop    (rd_pop),
  .rd_data   (rd_data),
  .rd_ferr   (rd_ferr),
  .rd_brk    (rd_brk),
  .data_ready(data_ready),
  .ovr_evt   (ovr_evt),
  .frm_push  (frm_push),
  .fifo_full (fifo_full),
  .fifo_level(fifo_level)
);

// File: tb/test_osr_rx.sv
module test_osr_rx;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en = 1'b0;
  logic       rx_in;
  logic [1:0] cfg_len;
  logic       cfg_par_en, cfg_par_even, cfg_par_stick;
  logic       rd_pop;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, data_ready, ovr_evt;

  int n_run  = 0;
  int n_fail = 0;
  int ovr_cnt = 0;
  int tdiv = 0;

  osr_rx i_osr_rx (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_in(rx_in),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .rd_pop(rd_pop), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .data_ready(data_ready), .ovr_evt(ovr_evt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (tdiv == TICK_DIV - 1) begin tdiv <= 0; tick_en <= 1'b1; end
    else begin tdiv <= tdiv + 1; tick_en <= 1'b0; end
  end

  always @(posedge clk) if (rst_n && ovr_evt) ovr_cnt <= ovr_cnt + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic line_bit(input logic b);
    rx_in = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // nb data bits LSB first, optional parity bit, one stop bit, then one idle bit
  task automatic send_frame(input logic [7:0] d, input int nb, input bit has_par,
                            input logic pbit, input logic stop);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    if (has_par) line_bit(pbit);
    line_bit(stop);
    line_bit(1'b1);
  endtask

  task automatic pop_expect(input string tag, input logic [7:0] d,
                            input logic pe, input logic fe, input logic bk);
    @(negedge clk);
    check(data_ready == 1'b1, {tag, " ready"}, data_ready, 1);
    check(rd_data == d, {tag, " data"}, rd_data, d);
    check(rd_perr == pe, {tag, " perr"}, rd_perr, pe);
    check(rd_ferr == fe, {tag, " ferr"}, rd_ferr, fe);
    check(rd_brk == bk, {tag, " brk"}, rd_brk, bk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic expect_empty(input string tag);
    @(negedge clk);
    check(data_ready == 1'b0, tag, data_ready, 0);
  endtask

  task automatic set_cfg(input logic [1:0] len, input logic pen,
                         input logic pev, input logic pst);
    cfg_len = len; cfg_par_en = pen; cfg_par_even = pev; cfg_par_stick = pst;
  endtask

  task automatic t_reset_idle;
    check(data_ready == 1'b0, "R1 ready after reset", data_ready, 0);
    check(ovr_evt == 1'b0, "R1 ovr after reset", ovr_evt, 0);
    repeat (8 * BIT_CLKS) @(negedge clk);
    check(data_ready == 1'b0, "R1 idle line", data_ready, 0);
  endtask

  task automatic t_basic8;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    send_frame(8'hA5, 8, 0, 1'b0, 1'b1);
    send_frame(8'h3C, 8, 0, 1'b0, 1'b1);
    pop_expect("R8 R3 first", 8'hA5, 0, 0, 0);
    pop_expect("R8 R3 second", 8'h3C, 0, 0, 0);
    expect_empty("R8 empty after pops");
  endtask

  task automatic t_short_words;
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0);
    send_frame(8'h16, 5, 0, 1'b0, 1'b1);
    pop_expect("R3 5-bit", 8'h16, 0, 0, 0);
    set_cfg(2'd2, 1'b0, 1'b0, 1'b0);
    send_frame(8'h5A, 7, 0, 1'b0, 1'b1);
    pop_expect("R3 7-bit", 8'h5A, 0, 0, 0);
  endtask

  task automatic t_parity;
    // 8'h53 has four ones: even parity bit 0, odd parity bit 1
    set_cfg(2'd3, 1'b1, 1'b1, 1'b0);
    send_frame(8'h53, 8, 1, 1'b0, 1'b1);
    pop_expect("R4 even good", 8'h53, 0, 0, 0);
    send_frame(8'h53, 8, 1, 1'b1, 1'b1);
    pop_expect("R4 even bad", 8'h53, 1, 0, 0);
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
    send_frame(8'h53, 8, 1, 1'b1, 1'b1);
    pop_expect("R4 odd good", 8'h53, 0, 0, 0);
    send_frame(8'h53, 8, 1, 1'b0, 1'b1);
    pop_expect("R4 odd bad", 8'h53, 1, 0, 0);
    set_cfg(2'd3, 1'b1, 1'b0, 1'b1);
    send_frame(8'h01, 8, 1, 1'b1, 1'b1);
    pop_expect("R4 stick1 good", 8'h01, 0, 0, 0);
    send_frame(8'h01, 8, 1, 1'b0, 1'b1);
    pop_expect("R4 stick1 bad", 8'h01, 1, 0, 0);
    set_cfg(2'd3, 1'b1, 1'b1, 1'b1);
    send_frame(8'h01, 8, 1, 1'b1, 1'b1);
    pop_expect("R4 stick0 bad", 8'h01, 1, 0, 0);
    send_frame(8'h01, 8, 1, 1'b0, 1'b1);
    pop_expect("R4 stick0 good", 8'h01, 0, 0, 0);
  endtask

  task automatic t_glitch;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    rx_in = 1'b0;
    repeat (5 * TICK_DIV) @(negedge clk);
    rx_in = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check(data_ready == 1'b0, "R2 glitch rejected", data_ready, 0);
  endtask

  task automatic t_framing;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    send_frame(8'h81, 8, 0, 1'b0, 1'b0);
    send_frame(8'h42, 8, 0, 1'b0, 1'b1);
    pop_expect("R6 stop low", 8'h81, 0, 1, 0);
    pop_expect("R6 recovery", 8'h42, 0, 0, 0);
  endtask

  task automatic t_break;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    rx_in = 1'b0;
    repeat (25 * BIT_CLKS) @(negedge clk);
    rx_in = 1'b1;
    repeat (2 * BIT_CLKS) @(negedge clk);
    pop_expect("R7 break entry", 8'h00, 0, 1, 1);
    expect_empty("R7 single break entry");
  endtask

  task automatic t_overrun;
    int start_ovr;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    start_ovr = ovr_cnt;
    for (int i = 0; i < 17; i++) send_frame(8'(8'h10 + i), 8, 0, 1'b0, 1'b1);
    check(ovr_cnt == start_ovr + 1, "R5 overrun pulse", ovr_cnt - start_ovr, 1);
    for (int i = 0; i < 16; i++) pop_expect("R5 kept entry", 8'(8'h10 + i), 0, 0, 0);
    expect_empty("R5 dropped byte absent");
  endtask

  initial begin
    rst_n = 1'b0; rx_in = 1'b1; rd_pop = 1'b0;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_basic8();
    t_short_words();
    t_parity();
    t_glitch();
    t_framing();
    t_break();
    t_overrun();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule